// File: doc/BRIEF.md
# SDRAM Command Monitor and Bank State Tracker

This block sits beside the control pins of a single-data-rate SDRAM and turns every rising clock edge into one decoded command. It reads the chip select, row strobe, column strobe and write enable (all active low), the clock enable, the data mask, the two bank bits and the twelve address bits. From these it keeps an open or closed flag and the last activated row for each of four banks. It also holds the most recently loaded mode word and raises a one-cycle error pulse when a command does not fit the current bank state.

The data-mask pin controls writes at once and reads two clocks later. The block therefore provides a write-mask output with the same timing as the decoded command, and a read output-enable that trails it by two further clocks. A controller model, a protocol monitor or a memory model can use these outputs to learn what the pins meant in any cycle, without decoding the pins itself.

Top module: `sdram_cmd_tracker`

## Requirements
- R1: One clock after the pins are sampled, `cmd_o` shows the decoded command, using these codes: 0 inhibit (cs_ni high), 1 NOP (ras/cas/we = H,H,H), 2 ACTIVE (L,H,H), 3 READ (H,L,H), 4 WRITE (H,L,L), 5 BURST TERMINATE (H,H,L), 6 PRECHARGE (L,H,L), 7 AUTO REFRESH (L,L,H with cke_i high), 8 SELF REFRESH entry (L,L,H with cke_i low), 9 LOAD MODE (L,L,L), 10 illegal. In the same cycle, `cmd_ba_o` and `cmd_addr_o` show the sampled bank and address.
- R2: ACTIVE marks the bank chosen by `ba_i` as open and stores `addr_i[11:0]` as that bank's row. The row of bank b appears on `open_row_o[12*b +: 12]`, and the change is visible one clock after sampling.
- R3: READ or WRITE to an open bank with `addr_i[10]` low leaves the bank open. With `addr_i[10]` high, the bank stays open in the first cycle after sampling and shows closed from the second cycle on.
- R4: PRECHARGE with `addr_i[10]` low closes only the bank named by `ba_i`. With `addr_i[10]` high it closes every bank and ignores `ba_i`.
- R5: The refresh encoding decodes as AUTO REFRESH when `cke_i` is high and as SELF REFRESH when `cke_i` is low. Neither one changes bank state or rows.
- R6: LOAD MODE captures `addr_i[11:0]` into `mode_o`, and the new value is visible one clock after sampling.
- R7: `err_o` pulses high in the same cycle as `cmd_o` in these cases: READ, WRITE or BURST TERMINATE to a closed bank; ACTIVE to an open bank; AUTO REFRESH, SELF REFRESH or LOAD MODE while any bank is open. ACTIVE to an open bank still reloads that bank's row, and LOAD MODE while a bank is open still loads `mode_o`.
- R8: With `cke_i` low, ACTIVE, READ, WRITE, BURST TERMINATE, PRECHARGE and LOAD MODE decode as code 10 (illegal). They raise `err_o` and change no bank state and no mode. NOP and inhibit keep their normal codes with no error.
- R9: `wr_mask_o` equals `dqm_i`, delayed one clock (write masking has zero latency relative to the command).
- R10: `rd_oe_o` equals the inverse of `dqm_i` sampled two edges before the edge that updates `rd_oe_o`. This is two clocks later than `wr_mask_o` reflects the same pin value.
- R11: While `rst_ni` is low, the block is forced to this state: `cmd_o` = 1 (NOP), every bank closed, all rows zero, `mode_o` = 0, `err_o` = 0, `wr_mask_o` = 1 and `rd_oe_o` = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Memory clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| cs_ni | input | 1 | Chip select, active low |
| ras_ni | input | 1 | Row strobe, active low |
| cas_ni | input | 1 | Column strobe, active low |
| we_ni | input | 1 | Write enable, active low |
| cke_i | input | 1 | Clock enable |
| dqm_i | input | 1 | Data mask pin |
| ba_i | input | 2 | Bank select |
| addr_i | input | 12 | Row, column or mode address |
| cmd_o | output | 4 | Registered command code |
| cmd_ba_o | output | 2 | Registered bank field |
| cmd_addr_o | output | 12 | Registered address field |
| bank_open_o | output | 4 | Open flag for each bank |
| open_row_o | output | 48 | Rows of banks 0..3, packed 12 bits each |
| mode_o | output | 12 | Current mode word |
| wr_mask_o | output | 1 | Write data mask |
| rd_oe_o | output | 1 | Read data output enable |
| err_o | output | 1 | Illegal sequence pulse |

## Verification
The decoded command, the bank and address echo, the error pulse, the bank flags, the rows, the mode word and the write mask all change at the first edge after the pins are sampled. The auto-precharge close shows up one edge after that, and the read enable two edges after the write mask. The bench drives each vector on a falling edge and pushes the values expected after the next rising edge into a queue. A monitor then compares them one time unit after that rising edge. The bench's own model applies the pending auto-precharge close one vector late and keeps the last two mask values. This way each check lands in the cycle where its result is due.

// File: rtl/sdram_trk_pkg.sv
package sdram_trk_pkg;
  typedef enum logic [3:0] {
    C_INH  = 4'd0,
    C_NOP  = 4'd1,
    C_ACT  = 4'd2,
    C_RD   = 4'd3,
    C_WR   = 4'd4,
    C_BST  = 4'd5,
    C_PRE  = 4'd6,
    C_AREF = 4'd7,
    C_SREF = 4'd8,
    C_LMR  = 4'd9,
    C_ILL  = 4'd10
  } cmd_e;
endpackage

// File: rtl/sdram_cmd_decode.sv
module sdram_cmd_decode
  import sdram_trk_pkg::*;
(
  input  logic cs_ni,
  input  logic ras_ni,
  input  logic cas_ni,
  input  logic we_ni,
  input  logic cke_i,
  output cmd_e cmd_o
);
  cmd_e raw;

  always_comb begin
    if (cs_ni) raw = C_INH;
    else begin
      unique case ({ras_ni, cas_ni, we_ni})
        3'b111:  raw = C_NOP;
        3'b011:  raw = C_ACT;
        3'b101:  raw = C_RD;
        3'b100:  raw = C_WR;
        3'b110:  raw = C_BST;
        3'b010:  raw = C_PRE;
        3'b001:  raw = cke_i ? C_AREF : C_SREF;
        default: raw = C_LMR;
      endcase
    end
  end

  // everything but inhibit, NOP and refresh needs clock enable high
  always_comb begin
    cmd_o = raw;
    if (!cke_i && raw != C_INH && raw != C_NOP && raw != C_AREF && raw != C_SREF)
      cmd_o = C_ILL;
  end
endmodule

// File: rtl/sdram_bank_track.sv
module sdram_bank_track
  import sdram_trk_pkg::*;
#(
  parameter int NBANK  = 4,
  parameter int ROW_W  = 12,
  parameter int AP_BIT = 10,
  localparam int BA_W  = $clog2(NBANK)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  cmd_e             cmd_i,
  input  logic [BA_W-1:0]  ba_i,
  input  logic [ROW_W-1:0] addr_i,
  output logic [NBANK-1:0] open_o,
  output logic [ROW_W-1:0] row_o [NBANK],
  output logic             err_o
);
  logic [NBANK-1:0] open_q, open_d;
  logic [ROW_W-1:0] row_q [NBANK];
  logic             ap_q, ap_d;
  logic [BA_W-1:0]  ap_ba_q;
  logic             hit, any_open, err_d;

  assign hit      = open_q[ba_i];
  assign any_open = |open_q;

  always_comb begin
    unique case (cmd_i)
      C_RD, C_WR, C_BST:     err_d = !hit;
      C_ACT:                 err_d = hit;
      C_AREF, C_SREF, C_LMR: err_d = any_open;
      C_ILL:                 err_d = 1'b1;
      default:               err_d = 1'b0;
    endcase
  end

  // pending auto-precharge close first, then this cycle's command
  always_comb begin
    open_d = open_q;
    if (ap_q) open_d[ap_ba_q] = 1'b0;
    if (cmd_i == C_ACT) open_d[ba_i] = 1'b1;
    if (cmd_i == C_PRE) begin
      if (addr_i[AP_BIT]) open_d = '0;
      else                open_d[ba_i] = 1'b0;
    end
  end

  assign ap_d = (cmd_i == C_RD || cmd_i == C_WR) && hit && addr_i[AP_BIT];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      open_q  <= '0;
      ap_q    <= 1'b0;
      ap_ba_q <= '0;
      err_o   <= 1'b0;
      for (int b = 0; b < NBANK; b++) row_q[b] <= '0;
    end else begin
      open_q  <= open_d;
      ap_q    <= ap_d;
      ap_ba_q <= ba_i;
      err_o   <= err_d;
      if (cmd_i == C_ACT) row_q[ba_i] <= addr_i;
    end
  end

  assign open_o = open_q;
  assign row_o  = row_q;
endmodule

// File: rtl/sdram_dqm_pipe.sv
module sdram_dqm_pipe #(
  parameter int RD_LAT = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic dqm_i,
  output logic wr_mask_o,
  output logic rd_oe_o
);
  logic [RD_LAT:0] st_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) st_q <= '1;
    else         st_q <= {st_q[RD_LAT-1:0], dqm_i};
  end

  assign wr_mask_o = st_q[0];
  assign rd_oe_o   = !st_q[RD_LAT];
endmodule

// File: rtl/sdram_cmd_tracker.sv
module sdram_cmd_tracker
  import sdram_trk_pkg::*;
#(
  parameter int NBANK  = 4,
  parameter int ADDR_W = 12,
  parameter int AP_BIT = 10,
  parameter int RD_LAT = 2,
  localparam int BA_W  = $clog2(NBANK)
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    cs_ni,
  input  logic                    ras_ni,
  input  logic                    cas_ni,
  input  logic                    we_ni,
  input  logic                    cke_i,
  input  logic                    dqm_i,
  input  logic [BA_W-1:0]         ba_i,
  input  logic [ADDR_W-1:0]       addr_i,
  output logic [3:0]              cmd_o,
  output logic [BA_W-1:0]         cmd_ba_o,
  output logic [ADDR_W-1:0]       cmd_addr_o,
  output logic [NBANK-1:0]        bank_open_o,
  output logic [NBANK*ADDR_W-1:0] open_row_o,
  output logic [ADDR_W-1:0]       mode_o,
  output logic                    wr_mask_o,
  output logic                    rd_oe_o,
  output logic                    err_o
);
  cmd_e              cmd_d, cmd_q;
  logic [BA_W-1:0]   ba_q;
  logic [ADDR_W-1:0] addr_q, mode_q;
  logic [ADDR_W-1:0] rows [NBANK];

  sdram_cmd_decode i_dec (
    .cs_ni  (cs_ni),
    .ras_ni (ras_ni),
    .cas_ni (cas_ni),
    .we_ni  (we_ni),
    .cke_i  (cke_i),
    .cmd_o  (cmd_d)
  );

  sdram_bank_track #(
    .NBANK  (NBANK),
    .ROW_W  (ADDR_W),
    .AP_BIT (AP_BIT)
  ) i_banks (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .cmd_i  (cmd_d),
    .ba_i   (ba_i),
    .addr_i (addr_i),
    .open_o (bank_open_o),
    .row_o  (rows),
    .err_o  (err_o)
  );

  sdram_dqm_pipe #(.RD_LAT(RD_LAT)) i_dqm (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .dqm_i     (dqm_i),
    .wr_mask_o (wr_mask_o),
    .rd_oe_o   (rd_oe_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cmd_q  <= C_NOP;
      ba_q   <= '0;
      addr_q <= '0;
      mode_q <= '0;
    end else begin
      cmd_q  <= cmd_d;
      ba_q   <= ba_i;
      addr_q <= addr_i;
      if (cmd_d == C_LMR) mode_q <= addr_i;
    end
  end

  for (genvar b = 0; b < NBANK; b++) begin : g_row
    assign open_row_o[b*ADDR_W +: ADDR_W] = rows[b];
  end

  assign cmd_o      = cmd_q;
  assign cmd_ba_o   = ba_q;
  assign cmd_addr_o = addr_q;
  assign mode_o     = mode_q;
endmodule

// File: rtl/sdram_cmd_tracker_chk.sv
module sdram_cmd_tracker_chk #(
  parameter int NBANK  = 4,
  parameter int ADDR_W = 12,
  localparam int BA_W  = $clog2(NBANK)
) (
  input logic                    clk_i,
  input logic                    rst_ni,
  input logic                    cs_ni,
  input logic                    ras_ni,
  input logic                    cas_ni,
  input logic                    we_ni,
  input logic                    cke_i,
  input logic                    dqm_i,
  input logic [BA_W-1:0]         ba_i,
  input logic [ADDR_W-1:0]       addr_i,
  input logic [3:0]              cmd_o,
  input logic [NBANK-1:0]        bank_open_o,
  input logic [NBANK*ADDR_W-1:0] open_row_o,
  input logic [ADDR_W-1:0]       mode_o,
  input logic                    wr_mask_o,
  input logic                    rd_oe_o,
  input logic                    err_o
);
  logic [1:0] cyc_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)           cyc_q <= '0;
    else if (cyc_q != 2'd3) cyc_q <= cyc_q + 2'd1;
  end

  logic pin_nop, pin_act, pin_rd, pin_pre, pin_lmr;
  assign pin_nop = !cs_ni &&  ras_ni &&  cas_ni &&  we_ni && cke_i;
  assign pin_act = !cs_ni && !ras_ni &&  cas_ni &&  we_ni && cke_i;
  assign pin_rd  = !cs_ni &&  ras_ni && !cas_ni &&  we_ni && cke_i;
  assign pin_pre = !cs_ni && !ras_ni &&  cas_ni && !we_ni && cke_i;
  assign pin_lmr = !cs_ni && !ras_ni && !cas_ni && !we_ni && cke_i;

  a_r1_nop_code: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pin_nop |=> cmd_o == 4'd1);

  a_r2_act_opens: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pin_act |=> bank_open_o[$past(ba_i)] &&
                open_row_o[$past(ba_i)*ADDR_W +: ADDR_W] == $past(addr_i));

  a_r4_pre_all: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pin_pre && addr_i[10]) |=> bank_open_o == '0);

  a_r6_mode_load: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pin_lmr |=> mode_o == $past(addr_i));

  a_r7_read_closed: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pin_rd && !bank_open_o[ba_i]) |=> err_o);

  a_r9_wr_mask: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cyc_q >= 2'd1) |-> wr_mask_o == $past(dqm_i));

  // fixed depth matches the default read latency of two
  a_r10_rd_oe: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cyc_q == 2'd3) |-> rd_oe_o == !$past(dqm_i, 3));
endmodule

bind sdram_cmd_tracker sdram_cmd_tracker_chk #(.NBANK(NBANK), .ADDR_W(ADDR_W)) i_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .cs_ni       (cs_ni),
  .ras_ni      (ras_ni),
  .cas_ni      (cas_ni),
  .we_ni       (we_ni),
  .cke_i       (cke_i),
  .dqm_i       (dqm_i),
  .ba_i        (ba_i),
  .addr_i      (addr_i),
  .cmd_o       (cmd_o),
  .bank_open_o (bank_open_o),
  .open_row_o  (open_row_o),
  .mode_o      (mode_o),
  .wr_mask_o   (wr_mask_o),
  .rd_oe_o     (rd_oe_o),
  .err_o       (err_o)
);

// File: tb/test_sdram_cmd_tracker.sv
`timescale 1ns/1ps
module test_sdram_cmd_tracker;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cs_n = 1'b1, ras_n = 1'b1, cas_n = 1'b1, we_n = 1'b1, cke = 1'b1, dqm = 1'b1;
  logic [1:0]  ba = '0;
  logic [11:0] addr = '0;
  logic [3:0]  cmd_o;
  logic [1:0]  cmd_ba_o;
  logic [11:0] cmd_addr_o, mode_o;
  logic [3:0]  bank_open_o;
  logic [47:0] open_row_o;
  logic        wr_mask_o, rd_oe_o, err_o;

  always #4 clk = ~clk;

  sdram_cmd_tracker i_sdram_cmd_tracker (
    .clk_i(clk), .rst_ni(rst_n), .cs_ni(cs_n), .ras_ni(ras_n), .cas_ni(cas_n),
    .we_ni(we_n), .cke_i(cke), .dqm_i(dqm), .ba_i(ba), .addr_i(addr),
    .cmd_o(cmd_o), .cmd_ba_o(cmd_ba_o), .cmd_addr_o(cmd_addr_o),
    .bank_open_o(bank_open_o), .open_row_o(open_row_o), .mode_o(mode_o),
    .wr_mask_o(wr_mask_o), .rd_oe_o(rd_oe_o), .err_o(err_o)
  );

  typedef struct packed {
    logic [3:0]  cmd;
    logic [1:0]  ba;
    logic [11:0] addr;
    logic        err;
    logic [3:0]  open;
    logic [47:0] rows;
    logic [11:0] mode;
    logic        wr;
    logic        rd;
  } exp_t;

  exp_t  exp_q[$];
  string tag_q[$];
  int n_chk = 0, n_bad = 0;

  // bench reference state
  logic [3:0]  m_open = '0;
  logic [47:0] m_rows = '0;
  logic [11:0] m_mode = '0;
  logic        m_ap = 1'b0;
  logic [1:0]  m_ap_ba = '0;
  logic [1:0]  m_hist = 2'b11;

  task automatic check(input bit ok, input string what, input string req,
                       input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic issue(input logic c, input logic r, input logic a, input logic w,
                       input logic k, input logic m, input logic [1:0] b,
                       input logic [11:0] ad, input string tag);
    exp_t e;
    logic [3:0] code;
    logic hit, anyo, nap;
    @(negedge clk);
    cs_n = c; ras_n = r; cas_n = a; we_n = w; cke = k; dqm = m; ba = b; addr = ad;
    if (c) code = 4'd0;
    else case ({r, a, w})
      3'b111: code = 4'd1;
      3'b011: code = 4'd2;
      3'b101: code = 4'd3;
      3'b100: code = 4'd4;
      3'b110: code = 4'd5;
      3'b010: code = 4'd6;
      3'b001: code = k ? 4'd7 : 4'd8;
      default: code = 4'd9;
    endcase
    if (!k && code != 4'd0 && code != 4'd1 && code != 4'd7 && code != 4'd8) code = 4'd10;
    hit  = m_open[b];
    anyo = |m_open;
    case (code)
      4'd3, 4'd4, 4'd5: e.err = !hit;
      4'd2:             e.err = hit;
      4'd7, 4'd8, 4'd9: e.err = anyo;
      4'd10:            e.err = 1'b1;
      default:          e.err = 1'b0;
    endcase
    if (m_ap) m_open[m_ap_ba] = 1'b0;
    if (code == 4'd2) begin
      m_open[b] = 1'b1;
      m_rows[b*12 +: 12] = ad;
    end
    if (code == 4'd6) begin
      if (ad[10]) m_open = '0;
      else        m_open[b] = 1'b0;
    end
    if (code == 4'd9) m_mode = ad;
    nap     = (code == 4'd3 || code == 4'd4) && hit && ad[10];
    m_ap    = nap;
    m_ap_ba = b;
    e.cmd  = code;
    e.ba   = b;
    e.addr = ad;
    e.open = m_open;
    e.rows = m_rows;
    e.mode = m_mode;
    e.wr   = m;
    e.rd   = !m_hist[1];
    m_hist = {m_hist[0], m};
    exp_q.push_back(e);
    tag_q.push_back(tag);
  endtask

  task automatic nop(input logic m, input string tag);
    issue(1'b0, 1'b1, 1'b1, 1'b1, 1'b1, m, 2'd0, 12'h000, tag);
  endtask

  // monitor: results of the vector sampled at this edge
  always @(posedge clk) begin
    #1;
    if (exp_q.size() > 0) begin
      exp_t  e;
      string t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      check(cmd_o == e.cmd, "cmd", t, 64'(cmd_o), 64'(e.cmd));
      check(cmd_ba_o == e.ba && cmd_addr_o == e.addr, "echo", t,
            64'({cmd_ba_o, cmd_addr_o}), 64'({e.ba, e.addr}));
      check(err_o == e.err, "err", t, 64'(err_o), 64'(e.err));
      check(bank_open_o == e.open, "bank_open", t, 64'(bank_open_o), 64'(e.open));
      check(open_row_o == e.rows, "rows", t, 64'(open_row_o), 64'(e.rows));
      check(mode_o == e.mode, "mode", t, 64'(mode_o), 64'(e.mode));
      check(wr_mask_o == e.wr, "wr_mask", "R9", 64'(wr_mask_o), 64'(e.wr));
      check(rd_oe_o == e.rd, "rd_oe", "R10", 64'(rd_oe_o), 64'(e.rd));
    end
  end

  initial begin
    int cyc = 0;
    while (cyc < 100000) begin
      @(posedge clk);
      cyc++;
    end
    n_chk++;
    n_bad++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R11 reset state while reset is held
    check(cmd_o == 4'd1 && bank_open_o == 4'd0 && open_row_o == '0 && mode_o == '0 &&
          !err_o && wr_mask_o && !rd_oe_o, "reset", "R11",
          64'({cmd_o, bank_open_o, mode_o, err_o, wr_mask_o, rd_oe_o}),
          64'({4'd1, 4'd0, 12'd0, 1'b0, 1'b1, 1'b0}));
    rst_n = 1'b1;

    nop(1'b1, "R1");
    issue(1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 2'd3, 12'hfff, "R1");      // inhibit
    issue(1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 2'd0, 12'h033, "R6");      // load mode
    issue(1'b0, 1'b0, 1'b1, 1'b1, 1'b1, 1'b0, 2'd0, 12'h123, "R2");      // act b0
    issue(1'b0, 1'b0, 1'b1, 1'b1, 1'b1, 1'b0, 2'd2, 12'habc, "R2");      // act b2
    issue(1'b0, 1'b1, 1'b0, 1'b1, 1'b1, 1'b0, 2'd0, 12'h005, "R3");      // rd b0 keep open
    issue(1'b0, 1'b1, 1'b0, 1'b0, 1'b1, 1'b1, 2'd2, 12'h0a0, "R3");      // wr b2 masked
    issue(1'b0, 1'b1, 1'b0, 1'b1, 1'b1, 1'b0, 2'd1, 12'h010, "R7");      // rd closed b1
    issue(1'b0, 1'b0, 1'b1, 1'b1, 1'b1, 1'b0, 2'd0, 12'h777, "R7");      // act open b0
    issue(1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 2'd0, 12'h000, "R7");      // refresh while open
    issue(1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 2'd0, 12'h021, "R7");      // load mode while open
    issue(1'b0, 1'b1, 1'b1, 1'b0, 1'b1, 1'b0, 2'd0, 12'h000, "R1");      // bst open b0
    issue(1'b0, 1'b1, 1'b1, 1'b0, 1'b1, 1'b0, 2'd3, 12'h000, "R7");      // bst closed b3
    issue(1'b0, 1'b1, 1'b0, 1'b1, 1'b1, 1'b0, 2'd0, 12'h405, "R3");      // rd b0 auto-pre
    nop(1'b0, "R3");
    nop(1'b0, "R3");
    issue(1'b0, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 2'd2, 12'h4ff, "R3");      // wr b2 auto-pre
    nop(1'b0, "R3");
    issue(1'b0, 1'b0, 1'b1, 1'b1, 1'b1, 1'b0, 2'd1, 12'h0f1, "R2");      // act b1
    issue(1'b0, 1'b0, 1'b1, 1'b1, 1'b1, 1'b0, 2'd3, 12'h0f3, "R2");      // act b3
    issue(1'b0, 1'b0, 1'b1, 1'b1, 1'b1, 1'b0, 2'd0, 12'h0f0, "R2");      // act b0
    issue(1'b0, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 2'd1, 12'h000, "R4");      // pre b1 only
    issue(1'b0, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 2'd1, 12'h400, "R4");      // pre all, ba ignored
    issue(1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 2'd2, 12'h222, "R8");      // act, cke low
    issue(1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 2'd0, 12'h3ff, "R8");      // load mode, cke low
    issue(1'b0, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 2'd0, 12'h000, "R8");      // nop, cke low
    issue(1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 2'd0, 12'h000, "R5");      // self refresh
    issue(1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 2'd0, 12'h000, "R5");      // auto refresh
    nop(1'b1, "R10");
    nop(1'b0, "R10");
    nop(1'b0, "R10");
    nop(1'b1, "R10");
    nop(1'b0, "R10");
    nop(1'b1, "R10");
    nop(1'b1, "R10");
    nop(1'b0, "R10");
    nop(1'b0, "R10");
    nop(1'b0, "R10");
    repeat (3) @(negedge clk);
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule